// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block keeps a record of why the chip was last reset or aborted. Eight fault sources (clock failure, watchdog expiry, illegal processor mode, illegal address, illegal memory access, peripheral access violation, overlapping memory map, software-requested reset) each drive a one-cycle event input. The block also records power-on reset directly from its own reset pin. Each source owns one flag in a 16-bit status word. A flag that has been set stays set until software clears it or until power is applied again. Warm resets of the rest of the chip leave every flag as it was.

Software reads the word through a plain 16-bit read strobe. It clears flags by writing the word with a 0 in each bit to be cleared. A 1 in any bit leaves that bit as it is. Bits 6 to 0 carry no flag and always read as zero. Only the power-on reset input reaches the flag flops. The warm reset input only blocks software writes while the bus side of the chip is itself held in reset.

Top module: `rstcause_reg`

## Requirements
- R1: Event input ev_i[k] maps to flag bit 7+k: ev_i[0] software reset (bit 7), ev_i[1] overlapping memory map (bit 8), ev_i[2] peripheral access violation (bit 9), ev_i[3] illegal memory access (bit 10), ev_i[4] illegal address (bit 11), ev_i[5] illegal mode (bit 12), ev_i[6] watchdog (bit 13), ev_i[7] clock failure (bit 14). Bit 15 is the power-on flag.
- R2: An event high at a rising clock edge sets its flag, and the flag is visible from that edge onward. No flag is set without its event.
- R3: Flags accumulate. A flag that has been set stays 1 through later events and clock cycles until a write clears it.
- R4: A write (wr_en_i high and warm_rst_n_i high) clears every flag whose wdata_i bit is 0 at that edge. Flag bits written 1 are unchanged.
- R5: If an event and a write of 0 hit the same bit at the same edge, the set wins and the flag is 1 afterwards.
- R6: Bits 6 to 0 always read as 0, and writes to them have no effect.
- R7: While por_n_i is low, the word holds 16'h8000 (power-on flag 1, all others 0), whatever the events are. After por_n_i rises, the power-on flag stays 1 until software writes 0 to bit 15.
- R8: A low warm_rst_n_i changes no flag. Writes are ignored while it is low. Events are still recorded while it is low.
- R9: rdata_o equals the current flag word in the same cycle that rd_en_i is high, and is 0 when rd_en_i is low.
- R10: An event held high keeps its flag at 1 on every edge, even while the same bit is being written 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_n_i | input | 1 | Warm reset, active low, blocks writes only |
| ev_i | input | 8 | Fault event pulses, one per source |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data, 0 clears a flag |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Flag word while rd_en_i is high, else 0 |

## Verification
Every one of the 256 event combinations is driven. After each one, a clear mask taken from the pattern's own bit transitions is written. This shows whether each event reaches the correct bit, and whether a write clears only its zero bits and leaves its one bits alone. Directed cases cover the following:
- Events and writes during power-on and during warm reset. These separate the two reset domains.
- An event colliding with a clear, and an event held high while being cleared. These show the set-over-clear priority.
- Reads with the strobe high and low. These show the read path is combinational and gated.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
   localparam int unsigned RC_DATA_W = 16;
   localparam int unsigned RC_NUM_EV = 8;

   typedef enum int unsigned {
      RC_EV_SOFT    = 0,
      RC_EV_MAP     = 1,
      RC_EV_PERIPH  = 2,
      RC_EV_MEMACC  = 3,
      RC_EV_ADDR    = 4,
      RC_EV_MODE    = 5,
      RC_EV_WDOG    = 6,
      RC_EV_CLKFAIL = 7
   } rc_ev_idx_e;
endpackage

// File: rtl/rstcause_flag_bit.sv
// One sticky flag: asynchronous power-on value, set has priority over clear.
module rstcause_flag_bit #(
   parameter bit POR_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)   q_o <= POR_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/rstcause_wr_dec.sv
// Turns a write into a per-bit clear vector; zeros in the data clear.
module rstcause_wr_dec #(
   parameter int unsigned WIDTH = 9
) (
   input  logic             wr_en_i,
   input  logic             warm_rst_n_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] clr_o
);
   logic wr_ok;
   assign wr_ok = wr_en_i & warm_rst_n_i;
   assign clr_o = {WIDTH{wr_ok}} & ~wdata_i;
endmodule

// File: rtl/rstcause_rd_gate.sv
// Combinational read return, zero when not selected.
module rstcause_rd_gate #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             rd_en_i,
   input  logic [WIDTH-1:0] word_i,
   output logic [WIDTH-1:0] rdata_o
);
   assign rdata_o = rd_en_i ? word_i : '0;
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
   import rstcause_pkg::*;
#(
   parameter int unsigned DATA_W = RC_DATA_W,
   parameter int unsigned NUM_EV = RC_NUM_EV
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              warm_rst_n_i,
   input  logic [NUM_EV-1:0] ev_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned POR_BIT = DATA_W - 1;
   localparam int unsigned EV_LSB  = POR_BIT - NUM_EV;
   localparam int unsigned FLAG_W  = NUM_EV + 1;

   if (NUM_EV < 1 || NUM_EV + 2 > DATA_W) begin : g_bad_cfg
      $error("rstcause_reg: NUM_EV must leave at least one reserved bit");
   end

   logic [FLAG_W-1:0] clr_vec;
   logic [DATA_W-1:0] flag_q;
   logic              unused_rsvd_wdata;

   assign unused_rsvd_wdata = ^wdata_i[EV_LSB-1:0];

   rstcause_wr_dec #(.WIDTH(FLAG_W)) wr_dec_i (
      .wr_en_i      (wr_en_i),
      .warm_rst_n_i (warm_rst_n_i),
      .wdata_i      (wdata_i[POR_BIT:EV_LSB]),
      .clr_o        (clr_vec)
   );

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POR_BIT) begin : g_por
         rstcause_flag_bit #(.POR_VAL(1'b1)) flag_i (
            .clk_i   (clk_i),
            .por_n_i (por_n_i),
            .set_i   (1'b0),
            .clr_i   (clr_vec[b-EV_LSB]),
            .q_o     (flag_q[b])
         );
      end else if (b >= EV_LSB) begin : g_ev
         rstcause_flag_bit #(.POR_VAL(1'b0)) flag_i (
            .clk_i   (clk_i),
            .por_n_i (por_n_i),
            .set_i   (ev_i[b-EV_LSB]),
            .clr_i   (clr_vec[b-EV_LSB]),
            .q_o     (flag_q[b])
         );
      end else begin : g_rsvd
         assign flag_q[b] = 1'b0;
      end
   end

   rstcause_rd_gate #(.WIDTH(DATA_W)) rd_gate_i (
      .rd_en_i (rd_en_i),
      .word_i  (flag_q),
      .rdata_o (rdata_o)
   );
endmodule

// File: rtl/rstcause_chk.sv
module rstcause_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NUM_EV = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic              warm_rst_n,
   input logic [NUM_EV-1:0] ev,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] flags
);
   localparam int unsigned EV_LSB = DATA_W - 1 - NUM_EV;

   logic              seen;
   logic [DATA_W-1:0] ev_mask;
   logic              wr_ok;

   assign ev_mask = DATA_W'(ev) << EV_LSB;
   assign wr_ok   = wr_en & warm_rst_n;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!por_n)
      (ev != '0) |=> ((flags & $past(ev_mask)) == $past(ev_mask)));

   assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!por_n)
      seen |-> ((flags & ~$past(flags) & ~$past(ev_mask)) == '0));

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
      (seen && !$past(wr_ok)) |-> (($past(flags) & ~flags) == '0));

   assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!por_n)
      seen |-> (($past(flags) & ~flags & $past(wdata)) == '0));

   assert_write_zero_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
      wr_ok |=> ((flags & ~$past(wdata) & ~$past(ev_mask)) == '0));

   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ok && ev != '0) |=> ((flags & $past(ev_mask)) == $past(ev_mask)));

   assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
      (rdata[EV_LSB-1:0] == '0) && (flags[EV_LSB-1:0] == '0));

   assert_warm_no_clear_R8: assert property (@(posedge clk) disable iff (!por_n)
      !warm_rst_n |=> (($past(flags) & ~flags) == '0));

   assert_read_value_R9: assert property (@(posedge clk) disable iff (!por_n)
      rd_en |-> (rdata == flags));

   assert_read_idle_R9: assert property (@(posedge clk) disable iff (!por_n)
      !rd_en |-> (rdata == '0));
endmodule

bind rstcause_reg rstcause_chk #(.DATA_W(DATA_W), .NUM_EV(NUM_EV)) chk_i (
   .clk        (clk_i),
   .por_n      (por_n_i),
   .warm_rst_n (warm_rst_n_i),
   .ev         (ev_i),
   .wr_en      (wr_en_i),
   .wdata      (wdata_i),
   .rd_en      (rd_en_i),
   .rdata      (rdata_o),
   .flags      (flag_q)
);

// File: tb/rstcause_reg_tb_top.sv
module rstcause_reg_tb_top;
   logic        clk_i = 1'b0;
   logic        por_n_i = 1'b0;
   logic        warm_rst_n_i = 1'b0;
   logic [7:0]  ev_i = '0;
   logic        wr_en_i = 1'b0;
   logic [15:0] wdata_i = '0;
   logic        rd_en_i = 1'b1;
   logic [15:0] rdata_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk_i = ~clk_i;

   rstcause_reg dut_i (
      .clk_i        (clk_i),
      .por_n_i      (por_n_i),
      .warm_rst_n_i (warm_rst_n_i),
      .ev_i         (ev_i),
      .wr_en_i      (wr_en_i),
      .wdata_i      (wdata_i),
      .rd_en_i      (rd_en_i),
      .rdata_o      (rdata_o)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus; on return the edge has been taken and inputs are idle.
   task automatic step(input logic [7:0] ev, input logic we, input logic [15:0] wd);
      @(negedge clk_i);
      ev_i = ev; wr_en_i = we; wdata_i = wd;
      @(negedge clk_i);
      ev_i = '0; wr_en_i = 1'b0; wdata_i = '0;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp;
      // Power-on phase
      repeat (3) @(negedge clk_i);
      #1 chk("R7 por value", rdata_o, 16'h8000);
      @(negedge clk_i); ev_i = 8'hFF;
      @(negedge clk_i); #1 chk("R7 events masked in por", rdata_o, 16'h8000);
      ev_i = '0;
      @(negedge clk_i); por_n_i = 1'b1;
      #1 chk("R7 after por release", rdata_o, 16'h8000);

      // Warm reset still active
      step(8'h00, 1'b1, 16'h0000);
      chk("R8 write ignored in warm reset", rdata_o, 16'h8000);
      step(8'h40, 1'b0, 16'h0000);
      chk("R8 watchdog recorded in warm reset", rdata_o, 16'hA000);
      @(negedge clk_i); warm_rst_n_i = 1'b1;
      step(8'h00, 1'b0, 16'h0000);
      chk("R8 warm release keeps flags", rdata_o, 16'hA000);
      step(8'h00, 1'b1, 16'h7FFF);
      chk("R7 power flag cleared by write", rdata_o, 16'h2000);
      step(8'h00, 1'b1, 16'hFFFF);
      chk("R4 write ones no effect", rdata_o, 16'h2000);
      step(8'h00, 1'b1, 16'h0000);
      chk("R4 write zero clears", rdata_o, 16'h0000);

      // R3 accumulation
      step(8'h01, 1'b0, 16'h0000);
      step(8'h40, 1'b0, 16'h0000);
      repeat (3) @(negedge clk_i);
      #1 chk("R3 flags accumulate", rdata_o, 16'h2080);

      // Exhaustive sweep over event patterns
      for (int p = 0; p < 256; p++) begin
         logic [7:0] q;
         logic [15:0] wd;
         step(8'h00, 1'b1, 16'h0000);
         step(p[7:0], 1'b0, 16'h0000);
         exp = {1'b0, p[7:0], 7'b0};
         chk(($countones(p) == 1) ? "R1 single event bit" : "R2 event pattern", rdata_o, exp);
         q  = p[7:0] ^ (p[7:0] >> 1);
         wd = {1'b1, ~q, p[6:0]};
         step(8'h00, 1'b1, wd);
         exp = exp & {1'b0, ~q, 7'b0};
         chk("R4 R6 masked clear", rdata_o, exp);
         step(8'h00, 1'b1, 16'hFFFF);
         chk("R4 ones keep", rdata_o, exp);
      end

      // R5 set wins over clear
      step(8'h00, 1'b1, 16'h0000);
      step(8'h20, 1'b0, 16'h0000);
      step(8'h08, 1'b1, 16'h0000);
      chk("R5 set beats same-cycle clear", rdata_o, 16'h0400);

      // R10 held event
      step(8'h00, 1'b1, 16'h0000);
      @(negedge clk_i); ev_i = 8'h40; wr_en_i = 1'b1; wdata_i = 16'h0000;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk_i);
         #1 chk("R10 held event survives clear", rdata_o, 16'h2000);
      end
      ev_i = '0;
      @(negedge clk_i);
      #1 chk("R10 clear after release", rdata_o, 16'h0000);
      wr_en_i = 1'b0;

      // R9 read gating
      step(8'h81, 1'b0, 16'h0000);
      @(negedge clk_i); rd_en_i = 1'b0;
      #1 chk("R9 idle read is zero", rdata_o, 16'h0000);
      rd_en_i = 1'b1;
      #1 chk("R9 same-cycle read", rdata_o, 16'h4080);

      // R6 reserved bits via write of zeros in low bits only
      step(8'h00, 1'b1, 16'hFF80);
      chk("R6 reserved write no effect", rdata_o, 16'h4080);

      // Second power-on wipes flags
      step(8'hFF, 1'b0, 16'h0000);
      chk("R2 all events", rdata_o, 16'h7F80);
      @(negedge clk_i); por_n_i = 1'b0;
      #1 chk("R7 por async clear", rdata_o, 16'h8000);
      @(negedge clk_i); por_n_i = 1'b1;
      step(8'h00, 1'b0, 16'h0000);
      chk("R7 power flag kept after por", rdata_o, 16'h8000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule